// File: doc/BRIEF.md
# Processor Sleep Entry and Exit Sequencer

This block sits in the system logic beside one or more processors. It takes them from the clock-stopped grant state into a deep sleep state and brings them back out. When the system raises its stop request, the sequencer drives the active-low stop-clock request. It then waits for every processor to report that its stop-grant bus cycle has finished. After that it counts a fixed settling interval and only then drives the active-low sleep request.

The sequencer times both the entry latency and the exit latency. It holds bus transactions off while either transition is under way. It leaves sleep when a snoop or an interrupt needs service, or when the system no longer wants sleep. An interrupt wake also releases the stop-clock request, so the processor returns to normal operation. A snoop wake leaves the processor in stop-grant.

A processor reset seen while asleep takes a separate abort path. It releases both requests at once and skips the stop-grant return. A wake that arrives before the sleep request has been driven cancels the entry.

Top module: `sleep_seq`

## Requirements
- R1: While `state` reads NORMAL (0), `slp_n` is high. The sleep request is never driven unless the stop-grant sequence has run first.
- R2: `slp_n` goes low exactly ENTRY_WAIT (default 100) clock edges after the edge that registers the last outstanding stop-grant completion.
- R3: With NUM_CPU processors, the entry wait does not start until every bit of `sg_done` has been seen high at least once since the sequencer entered STOPGRANT. While any processor is still missing, `slp_n` stays high.
- R4: `state` reads SLEEP (4) exactly TRANS_LAT (default 10) edges after `slp_n` falls. The state codes are: NORMAL 0, STOPGRANT 1, WAIT 2, ENTERING 3, SLEEP 4, EXITING 5, RESUME 6.
- R5: After a wake, `state` reads RESUME (6) exactly TRANS_LAT edges after `slp_n` rises. This is the point at which the processor is back in stop-grant.
- R6: `bus_block` is high whenever `state` is ENTERING or EXITING, and low in every other state.
- R7: A snoop wake (`snoop_pend` high in SLEEP) raises `slp_n` on the next edge and keeps `stpclk_n` low. The sequencer reads STOPGRANT (1) one edge after RESUME.
- R8: An interrupt wake (`irq_pend` high in SLEEP) raises `slp_n` on the next edge. It then raises `stpclk_n` and returns `state` to NORMAL one edge after RESUME, which is TRANS_LAT+1 edges after `slp_n` rose.
- R9: `cpu_rst` high while in SLEEP makes `slp_n` and `stpclk_n` both high and `state` NORMAL on the next edge, with no EXITING phase.
- R10: A wake (`snoop_pend` or `irq_pend`) during WAIT returns the sequencer to STOPGRANT on the next edge, and `slp_n` is never driven low.
- R11: The completion record is cleared whenever STOPGRANT is re-entered. A new entry therefore again needs every processor to report completion.
- R12: Synchronous reset `rst` gives `slp_n`=1, `stpclk_n`=1, `bus_block`=0 and `state`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset of the sequencer, active high |
| stop_req | input | 1 | System requests the stop-grant state |
| sleep_want | input | 1 | System requests deep sleep |
| sg_done | input | NUM_CPU | Per-processor pulse: stop-grant bus cycle completed |
| snoop_pend | input | 1 | A snoop needs service |
| irq_pend | input | 1 | An interrupt needs service |
| cpu_rst | input | 1 | Processor reset being driven by the system |
| slp_n | output | 1 | Sleep request, active low, registered |
| stpclk_n | output | 1 | Stop-clock request, active low, registered |
| bus_block | output | 1 | Hold off bus transactions |
| state | output | 3 | Current sequencer state code |

## Verification
The assertions assume that `rst` is applied before use. They also assume that `cpu_rst` and the wake inputs arrive only as short pulses, and that the system drives no snoop while `bus_block` is high. The stimulus drives inputs one cycle at a time on the falling edge. Wake and reset pulses are injected only when the sequencer is in WAIT or SLEEP, and are never injected during ENTERING or EXITING. Processor completion order, the gaps between completions, and the wake kind are drawn at random from a fixed seed.

// File: rtl/sleep_seq.sv
module sleep_seq #(
  parameter int NUM_CPU    = 2,
  parameter int ENTRY_WAIT = 100,
  parameter int TRANS_LAT  = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               stop_req,
  input  logic               sleep_want,
  input  logic [NUM_CPU-1:0] sg_done,
  input  logic               snoop_pend,
  input  logic               irq_pend,
  input  logic               cpu_rst,
  output logic               slp_n,
  output logic               stpclk_n,
  output logic               bus_block,
  output logic [2:0]         state
);
  localparam int WW = (ENTRY_WAIT > 1) ? $clog2(ENTRY_WAIT) : 1;
  localparam int LW = (TRANS_LAT > 1) ? $clog2(TRANS_LAT) : 1;
  localparam logic [WW-1:0] W_LAST = WW'(ENTRY_WAIT - 1);
  localparam logic [LW-1:0] L_LAST = LW'(TRANS_LAT - 1);

  localparam logic [2:0] S_NORM = 3'd0;
  localparam logic [2:0] S_SG   = 3'd1;
  localparam logic [2:0] S_WAIT = 3'd2;
  localparam logic [2:0] S_ENT  = 3'd3;
  localparam logic [2:0] S_SLP  = 3'd4;
  localparam logic [2:0] S_EXIT = 3'd5;
  localparam logic [2:0] S_RES  = 3'd6;

  logic [2:0]         st;
  logic [NUM_CPU-1:0] seen;
  logic [WW-1:0]      wcnt;
  logic [LW-1:0]      lcnt;
  logic               wake_irq;

  wire wake     = snoop_pend | irq_pend;
  wire all_done = &(seen | sg_done);

  assign state     = st;
  assign bus_block = (st == S_ENT) || (st == S_EXIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_NORM;
      slp_n    <= 1'b1;
      stpclk_n <= 1'b1;
      seen     <= '0;
      wcnt     <= '0;
      lcnt     <= '0;
      wake_irq <= 1'b0;
    end else begin
      case (st)
        S_NORM: begin
          seen <= '0;
          if (stop_req) begin
            st       <= S_SG;
            stpclk_n <= 1'b0;
          end
        end
        S_SG: begin
          seen <= seen | sg_done;
          if (!stop_req) begin
            st       <= S_NORM;
            stpclk_n <= 1'b1;
            seen     <= '0;
          end else if (all_done && sleep_want && !wake) begin
            st   <= S_WAIT;
            wcnt <= '0;
          end
        end
        S_WAIT: begin
          if (wake || !sleep_want || !stop_req) begin
            st   <= S_SG;
            seen <= '0;
          end else if (wcnt == W_LAST) begin
            st    <= S_ENT;
            slp_n <= 1'b0;
            lcnt  <= '0;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        S_ENT: begin
          if (lcnt == L_LAST) st <= S_SLP;
          else                lcnt <= lcnt + 1'b1;
        end
        S_SLP: begin
          if (cpu_rst) begin
            st       <= S_NORM;
            slp_n    <= 1'b1;
            stpclk_n <= 1'b1;
            seen     <= '0;
          end else if (wake || !sleep_want) begin
            st       <= S_EXIT;
            slp_n    <= 1'b1;
            lcnt     <= '0;
            wake_irq <= irq_pend;
          end
        end
        S_EXIT: begin
          if (lcnt == L_LAST) st <= S_RES;
          else                lcnt <= lcnt + 1'b1;
        end
        S_RES: begin
          wake_irq <= 1'b0;
          if (wake_irq) begin
            st       <= S_NORM;
            stpclk_n <= 1'b1;
          end else begin
            st   <= S_SG;
            seen <= '0;
          end
        end
        default: st <= S_NORM;
      endcase
    end
  end
endmodule

// File: rtl/sleep_seq_chk.sv
module sleep_seq_chk #(
  parameter int TRANS_LAT = 10
) (
  input logic       clk,
  input logic       rst,
  input logic       snoop_pend,
  input logic       irq_pend,
  input logic       cpu_rst,
  input logic       slp_n,
  input logic       stpclk_n,
  input logic       bus_block,
  input logic [2:0] state
);
  int low_run;

  always_ff @(posedge clk) begin
    if (rst || slp_n) low_run <= 0;
    else if (low_run < 1000) low_run <= low_run + 1;
  end

  a_r1_awake_in_normal: assert property (@(posedge clk) disable iff (rst)
    state == 3'd0 |-> slp_n);

  a_r2_fall_after_wait: assert property (@(posedge clk) disable iff (rst)
    $fell(slp_n) |-> $past(state) == 3'd2);

  a_r4_entry_latency: assert property (@(posedge clk) disable iff (rst)
    (state == 3'd4 && $past(state) == 3'd3) |-> low_run == TRANS_LAT);

  a_r6_block_in_transit: assert property (@(posedge clk) disable iff (rst)
    (!slp_n && state != 3'd4) |-> bus_block);

  a_r9_reset_abort: assert property (@(posedge clk) disable iff (rst)
    (state == 3'd4 && cpu_rst) |=> (slp_n && stpclk_n && state == 3'd0));

  a_r10_cancel_wait: assert property (@(posedge clk) disable iff (rst)
    (state == 3'd2 && (snoop_pend || irq_pend)) |=> (slp_n && state == 3'd1));
endmodule

bind sleep_seq sleep_seq_chk #(.TRANS_LAT(TRANS_LAT)) i_sleep_seq_chk (
  .clk(clk), .rst(rst), .snoop_pend(snoop_pend), .irq_pend(irq_pend),
  .cpu_rst(cpu_rst), .slp_n(slp_n), .stpclk_n(stpclk_n),
  .bus_block(bus_block), .state(state)
);

// File: tb/test_sleep_seq.sv
module test_sleep_seq;
  localparam int NCPU = 2;
  localparam int WAITN = 100;
  localparam int LAT = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stop_req = 1'b0, sleep_want = 1'b0;
  logic [NCPU-1:0] sg_done = '0;
  logic snoop_pend = 1'b0, irq_pend = 1'b0, cpu_rst = 1'b0;
  logic slp_n, stpclk_n, bus_block;
  logic [2:0] state;

  int errors = 0, checks = 0, cyc = 0;
  bit done_flag = 1'b0;

  always #2 clk = ~clk;

  sleep_seq #(.NUM_CPU(NCPU), .ENTRY_WAIT(WAITN), .TRANS_LAT(LAT)) i_sleep_seq (
    .clk(clk), .rst(rst), .stop_req(stop_req), .sleep_want(sleep_want),
    .sg_done(sg_done), .snoop_pend(snoop_pend), .irq_pend(irq_pend),
    .cpu_rst(cpu_rst), .slp_n(slp_n), .stpclk_n(stpclk_n),
    .bus_block(bus_block), .state(state)
  );

  function automatic int exp_entry();        return WAITN;   endfunction
  function automatic int exp_settle();       return LAT;     endfunction
  function automatic int exp_back(bit irq);  return LAT + 1; endfunction
  function automatic int exp_state_after(bit irq); return irq ? 0 : 1; endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic pulse_cpu(int idx);
    @(negedge clk) sg_done = NCPU'(1) << idx;
    @(negedge clk) sg_done = '0;
  endtask

  task automatic count_until_low(output int n);
    n = 0;
    while (slp_n && n < 400) begin @(negedge clk); n++; end
  endtask

  task automatic count_until_state(logic [2:0] s, output int n);
    n = 0;
    while (state != s && n < 400) begin @(negedge clk); n++; end
  endtask

  task automatic idle(int n, output bit ok);
    ok = 1'b1;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (!slp_n) ok = 1'b0; end
  endtask

  // completes all CPUs in random order, returns cycles to slp_n low
  task automatic enter(output int n);
    int first;
    bit ok;
    first = int'($urandom_range(NCPU - 1));
    for (int k = 0; k < NCPU - 1; k++) begin
      pulse_cpu((first + k) % NCPU);
      idle(int'($urandom_range(20, 5)), ok);
    end
    pulse_cpu((first + NCPU - 1) % NCPU);
    count_until_low(n);
  endtask

  initial begin
    int n;
    bit ok;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(slp_n && stpclk_n && !bus_block && state == 3'd0, "R12",
          {state, bus_block, stpclk_n, slp_n}, 3);

    sleep_want = 1'b1;
    idle(30, ok);
    check(ok && state == 3'd0, "R1", int'(ok), 1);

    @(negedge clk) stop_req = 1'b1;
    @(negedge clk);
    check(!stpclk_n && state == 3'd1, "R1 stpclk", {state, stpclk_n}, 2);

    pulse_cpu(0);
    idle(WAITN + 30, ok);
    check(ok && state == 3'd1, "R3", state, 1);
    pulse_cpu(1);
    count_until_low(n);
    check(n == exp_entry(), "R2", n, exp_entry());
    check(bus_block && state == 3'd3, "R6", bus_block, 1);
    count_until_state(3'd4, n);
    check(n == exp_settle(), "R4", n, exp_settle());
    check(!bus_block, "R6 sleep", bus_block, 0);

    for (int it = 0; it < 6; it++) begin
      bit irq;
      irq = bit'($urandom_range(1));
      repeat (int'($urandom_range(8, 1))) @(negedge clk);
      if (irq) irq_pend = 1'b1; else snoop_pend = 1'b1;
      @(negedge clk) begin irq_pend = 1'b0; snoop_pend = 1'b0; end
      check(slp_n && !stpclk_n && state == 3'd5 && bus_block, irq ? "R8" : "R7",
            {state, slp_n}, 11);
      count_until_state(3'd6, n);
      check(n == exp_settle(), "R5", n, exp_settle());
      @(negedge clk);
      check(state == 3'(exp_state_after(irq)) && stpclk_n == irq && !bus_block,
            irq ? "R8" : "R7", state, exp_state_after(irq));
      if (irq) begin
        @(negedge clk);
        check(!stpclk_n && state == 3'd1, "R11 resg", state, 1);
      end
      idle(WAITN + 20, ok);
      check(ok, "R11", int'(ok), 1);
      enter(n);
      check(n == exp_entry(), "R2 rand", n, exp_entry());
      count_until_state(3'd4, n);
      check(n == exp_settle(), "R4 rand", n, exp_settle());
    end

    @(negedge clk) cpu_rst = 1'b1;
    @(negedge clk) cpu_rst = 1'b0;
    check(slp_n && stpclk_n && state == 3'd0, "R9", {state, stpclk_n, slp_n}, 3);
    @(negedge clk) stop_req = 1'b0;
    @(negedge clk) stop_req = 1'b1;
    @(negedge clk);
    for (int k = 0; k < NCPU; k++) pulse_cpu(k);
    repeat (40) @(negedge clk);
    check(state == 3'd2, "R10 pre", state, 2);
    snoop_pend = 1'b1;
    @(negedge clk) snoop_pend = 1'b0;
    check(slp_n && state == 3'd1, "R10", state, 1);
    idle(WAITN + 20, ok);
    check(ok && state == 3'd1, "R10 hold", state, 1);

    finish_run();
  end
endmodule